// File: doc/BRIEF.md
# Downstream Hub Port Line Override and Monitor

This block sits between the port logic of a four-port USB hub and the pins of its downstream ports. Firmware reaches it through a small byte-wide register bus. Through that bus firmware can take over any port's D+/D− pair in two ways:

- A two-bit drive mode per port pushes a differential one, a differential zero or SE0 onto the pair.
- A per-pin hold-low mask pulls individual lines low. The mask also drives SE0 on every port while the hub is unconfigured or suspended.

The block also watches the received line pair of each port and reports two things. The first is whether the port currently sits in SE0. The second is the last differential value seen on the port, which is held while the port is in SE0.

The received lines are first brought into the clock domain by a two-stage synchronizer. The monitor registers then sample them. The drive-side registers are cleared only by the power-on reset. The monitor registers are also cleared by a USB bus reset.

Top module: `usb_dport_override`

## Requirements
- R1: While `rst` is high, every register reads 0 and every output enable (`oe_dp`, `oe_dm`) is 0.
- R2: The drive-mode register sits at offset 0x0, and port p (p = 0..3) uses bits [2p+1:2p] of it. The modes are:
  - 00: releases both pins (enable 0, value 0).
  - 01: drives D+ high and D− low.
  - 10: drives D+ low and D− high.
  - 11: drives both pins low.
  The register reads back what was written.
- R3: The hold-low mask sits at offset 0x1. Bit 2p is the D− pin of port p and bit 2p+1 is its D+ pin. A set bit enables that pin with value 0, and a clear bit leaves the pin to its drive mode. Writing 0xFF drives SE0 on all four ports. The mask reads back what was written.
- R4: When a mask bit is set, it overrides the drive mode of its pin, whatever that mode is.
- R5: The SE0 status register sits at offset 0x2. Bit p reads 1 while both received lines of port p are low. Bits 7:4 read 0. A change on `rx_dp`/`rx_dm` reaches this register on the third rising clock edge after the change (two synchronizer stages, then the register).
- R6: The differential data register sits at offset 0x3. Bit p reads 1 after port p was seen with D+ high and D− low, and 0 after D+ low and D− high. Bits 7:4 read 0. The latency is the same as in R5.
- R7: While both received lines of a port are equal (SE0, or both high), its data bit keeps the last differential value captured before that state.
- R8: A cycle with `bus_rst` high clears the SE0 status and data registers. It leaves the drive-mode register and the hold-low mask unchanged.
- R9: Writes to offsets 0x2 and 0x3 have no effect. Those registers still report only the line state.
- R10: Reads of offsets 0x4 to 0xF return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bus_rst | input | 1 | USB bus reset, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| rx_dp | input | 4 | Received D+ level per port |
| rx_dm | input | 4 | Received D− level per port |
| tx_dp | output | 4 | Driven D+ value per port |
| tx_dm | output | 4 | Driven D− value per port |
| oe_dp | output | 4 | D+ output enable per port |
| oe_dm | output | 4 | D− output enable per port |

## Verification
The hardest situation to reach from the ports is a data bit holding a value through SE0 while a bus reset lands. The line must first be set to a known differential state for long enough to cross the synchronizer. It is then dropped into SE0, and only after that is `bus_rst` pulsed. The bench walks a port through this sequence directly. It then checks that the data bit reads 0, that the drive-side registers still hold their values, and that the bit recovers from the next differential state. Random line patterns, each held longer than the three-cycle latency, mix J, K, SE0 and both-high states on all ports. The bench carries its own captured-value model through every one of them.

// File: rtl/dpo_pkg.sv
package dpo_pkg;

    localparam int REG_W = 8;

    localparam int OFS_MODE   = 0;
    localparam int OFS_HOLD   = 1;
    localparam int OFS_SE0    = 2;
    localparam int OFS_DIFF   = 3;

    typedef enum logic [1:0] {
        DRV_RELEASE = 2'b00,
        DRV_DIFF1   = 2'b01,
        DRV_DIFF0   = 2'b10,
        DRV_SE0     = 2'b11
    } drv_mode_e;

    typedef struct packed {
        logic dp_val;
        logic dm_val;
        logic dp_oe;
        logic dm_oe;
    } pin_drive_t;

    // Resolve one port's pin drive; a hold-low bit beats the mode field.
    function automatic pin_drive_t resolve_drive(drv_mode_e mode, logic hold_dp, logic hold_dm);
        pin_drive_t d;
        d = '0;
        unique case (mode)
            DRV_RELEASE: d = '{dp_val: 1'b0, dm_val: 1'b0, dp_oe: 1'b0, dm_oe: 1'b0};
            DRV_DIFF1:   d = '{dp_val: 1'b1, dm_val: 1'b0, dp_oe: 1'b1, dm_oe: 1'b1};
            DRV_DIFF0:   d = '{dp_val: 1'b0, dm_val: 1'b1, dp_oe: 1'b1, dm_oe: 1'b1};
            DRV_SE0:     d = '{dp_val: 1'b0, dm_val: 1'b0, dp_oe: 1'b1, dm_oe: 1'b1};
            default:     d = '0;
        endcase
        if (hold_dp) begin
            d.dp_val = 1'b0;
            d.dp_oe  = 1'b1;
        end
        if (hold_dm) begin
            d.dm_val = 1'b0;
            d.dm_oe  = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/dpo_sync.sv
module dpo_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dpo_port_mon.sv
module dpo_port_mon (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic dp_s,
    input  logic dm_s,
    output logic se0_q,
    output logic diff_q
);
    logic is_diff;

    assign is_diff = dp_s ^ dm_s;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            se0_q  <= 1'b0;
            diff_q <= 1'b0;
        end else begin
            se0_q <= ~dp_s & ~dm_s;
            if (is_diff) diff_q <= dp_s;
        end
    end
endmodule

// File: rtl/dpo_pin_drv.sv
module dpo_pin_drv
    import dpo_pkg::*;
(
    input  logic [1:0] mode_bits,
    input  logic       hold_dp,
    input  logic       hold_dm,
    output logic       tx_dp,
    output logic       tx_dm,
    output logic       oe_dp,
    output logic       oe_dm
);
    pin_drive_t drv;

    always_comb begin
        drv = resolve_drive(drv_mode_e'(mode_bits), hold_dp, hold_dm);
    end

    assign tx_dp = drv.dp_val;
    assign tx_dm = drv.dm_val;
    assign oe_dp = drv.dp_oe;
    assign oe_dm = drv.dm_oe;
endmodule

// File: rtl/usb_dport_override.sv
module usb_dport_override
    import dpo_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NPORTS-1:0] rx_dp,
    input  logic [NPORTS-1:0] rx_dm,
    output logic [NPORTS-1:0] tx_dp,
    output logic [NPORTS-1:0] tx_dm,
    output logic [NPORTS-1:0] oe_dp,
    output logic [NPORTS-1:0] oe_dm
);
    localparam int PIN_W = 2 * NPORTS;

    logic [PIN_W-1:0]  mode_q;
    logic [PIN_W-1:0]  hold_q;
    logic [NPORTS-1:0] se0_q;
    logic [NPORTS-1:0] diff_q;
    logic [NPORTS-1:0] dp_s;
    logic [NPORTS-1:0] dm_s;
    logic              wr_mode;
    logic              wr_hold;

    assign wr_mode = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
    assign wr_hold = reg_wr && (reg_addr == ADDR_W'(OFS_HOLD));

    // Drive-side registers: power-on reset only, bus reset has no effect.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            hold_q <= '0;
        end else begin
            if (wr_mode) mode_q <= reg_wdata[PIN_W-1:0];
            if (wr_hold) hold_q <= reg_wdata[PIN_W-1:0];
        end
    end

    dpo_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rx_dp, rx_dm}),
        .q   ({dp_s, dm_s})
    );

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            dpo_port_mon u_mon (
                .clk    (clk),
                .rst    (rst),
                .clr    (bus_rst),
                .dp_s   (dp_s[p]),
                .dm_s   (dm_s[p]),
                .se0_q  (se0_q[p]),
                .diff_q (diff_q[p])
            );

            dpo_pin_drv u_drv (
                .mode_bits (mode_q[2*p +: 2]),
                .hold_dp   (hold_q[2*p+1]),
                .hold_dm   (hold_q[2*p]),
                .tx_dp     (tx_dp[p]),
                .tx_dm     (tx_dm[p]),
                .oe_dp     (oe_dp[p]),
                .oe_dm     (oe_dm[p])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_MODE): reg_rdata[PIN_W-1:0]  = mode_q;
            ADDR_W'(OFS_HOLD): reg_rdata[PIN_W-1:0]  = hold_q;
            ADDR_W'(OFS_SE0):  reg_rdata[NPORTS-1:0] = se0_q;
            ADDR_W'(OFS_DIFF): reg_rdata[NPORTS-1:0] = diff_q;
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_dport_override_chk.sv
module usb_dport_override_chk
    import dpo_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_rst,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [REG_W-1:0]    reg_rdata,
    input logic [2*NPORTS-1:0] mode_q,
    input logic [2*NPORTS-1:0] hold_q,
    input logic [NPORTS-1:0]   se0_q,
    input logic [NPORTS-1:0]   diff_q,
    input logic [NPORTS-1:0]   dp_s,
    input logic [NPORTS-1:0]   dm_s,
    input logic [NPORTS-1:0]   tx_dp,
    input logic [NPORTS-1:0]   tx_dm,
    input logic [NPORTS-1:0]   oe_dp,
    input logic [NPORTS-1:0]   oe_dm
);
    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_pin
            AST_HOLD_DP_WINS: assert property (@(posedge clk) disable iff (rst)
                hold_q[2*p+1] |-> (oe_dp[p] && !tx_dp[p])); // R4
            AST_HOLD_DM_WINS: assert property (@(posedge clk) disable iff (rst)
                hold_q[2*p] |-> (oe_dm[p] && !tx_dm[p])); // R4
            AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
                (mode_q[2*p +: 2] == 2'b00 && hold_q[2*p +: 2] == 2'b00) |-> (!oe_dp[p] && !oe_dm[p])); // R2
        end
    endgenerate

    AST_BUSRST_CLEARS_MON: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (se0_q == '0 && diff_q == '0)); // R8

    AST_BUSRST_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (bus_rst && !(reg_wr && reg_addr == ADDR_W'(OFS_MODE))) |=> $stable(mode_q)); // R8

    AST_DIFF_HELD: assert property (@(posedge clk) disable iff (rst)
        !bus_rst |=> (((diff_q ^ $past(diff_q)) & $past(~(dp_s ^ dm_s))) == '0)); // R7

    AST_MON_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(OFS_SE0) || reg_addr == ADDR_W'(OFS_DIFF)) |-> ((reg_rdata >> NPORTS) == '0)); // R5

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > ADDR_W'(OFS_DIFF)) |-> (reg_rdata == '0)); // R10
endmodule

bind usb_dport_override usb_dport_override_chk #(
    .NPORTS (NPORTS),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/usb_dport_override_test.sv
module usb_dport_override_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] rx_dp = 4'hF;
    logic [3:0] rx_dm = 4'h0;
    logic [3:0] tx_dp, tx_dm, oe_dp, oe_dm;

    int total = 0;
    int fails = 0;
    logic [3:0] m_diff = '0;
    logic [7:0] m_mode = '0;
    logic [7:0] m_hold = '0;

    always #5 clk = ~clk;

    usb_dport_override uut (
        .clk       (clk),
        .rst       (rst),
        .bus_rst   (bus_rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_dp     (rx_dp),
        .rx_dm     (rx_dm),
        .tx_dp     (tx_dp),
        .tx_dm     (tx_dm),
        .oe_dp     (oe_dp),
        .oe_dm     (oe_dm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Expected {tx_dp, tx_dm, oe_dp, oe_dm} from mode and hold registers.
    function automatic logic [15:0] exp_pins(input logic [7:0] mode, input logic [7:0] hold);
        logic [3:0] vdp, vdm, edp, edm;
        for (int p = 0; p < 4; p++) begin
            case (mode[2*p +: 2])
                2'b00: begin vdp[p] = 0; vdm[p] = 0; edp[p] = 0; edm[p] = 0; end
                2'b01: begin vdp[p] = 1; vdm[p] = 0; edp[p] = 1; edm[p] = 1; end
                2'b10: begin vdp[p] = 0; vdm[p] = 1; edp[p] = 1; edm[p] = 1; end
                default: begin vdp[p] = 0; vdm[p] = 0; edp[p] = 1; edm[p] = 1; end
            endcase
            if (hold[2*p+1]) begin vdp[p] = 0; edp[p] = 1; end
            if (hold[2*p])   begin vdm[p] = 0; edm[p] = 1; end
        end
        return {vdp, vdm, edp, edm};
    endfunction

    task automatic check_pins(input string req);
        @(negedge clk);
        #1;
        check(req, {tx_dp, tx_dm, oe_dp, oe_dm}, exp_pins(m_mode, m_hold));
    endtask

    task automatic set_lines(input logic [3:0] dp, input logic [3:0] dm);
        @(negedge clk);
        rx_dp = dp;
        rx_dm = dm;
        for (int p = 0; p < 4; p++)
            if (dp[p] != dm[p]) m_diff[p] = dp[p];
        repeat (3) @(negedge clk);
    endtask

    task automatic check_mon(input string req);
        logic [7:0] v;
        rd(4'h2, v);
        check({req, " se0"}, v, {4'h0, ~rx_dp & ~rx_dm});
        rd(4'h3, v);
        check({req, " diff"}, v, {4'h0, m_diff});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] a;
        void'($urandom(32'h5EED_0042));

        // R1: registers and enables during reset
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            reg_addr = 4'(i);
            #1;
            check("R1 reg reset", reg_rdata, 8'h00);
        end
        check("R1 oe reset", {oe_dp, oe_dm}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        m_diff = 4'hF;

        // R2: one distinct mode per port
        m_mode = 8'b11_10_01_00;
        wr(4'h0, m_mode);
        check_pins("R2 modes per port");
        rd(4'h0, v);
        check("R2 readback", v, m_mode);

        // R3: mask corners
        m_mode = 8'h00;
        wr(4'h0, m_mode);
        m_hold = 8'h81;
        wr(4'h1, m_hold);
        check_pins("R3 D-[port0] and D+[port3]");
        m_hold = 8'hFF;
        wr(4'h1, m_hold);
        check_pins("R3 all SE0");
        rd(4'h1, v);
        check("R3 readback", v, m_hold);

        // R4: mask over every driven mode
        m_mode = 8'h55;
        wr(4'h0, m_mode);
        m_hold = 8'hAA;
        wr(4'h1, m_hold);
        check_pins("R4 hold D+ over diff1");
        m_mode = 8'hAA;
        wr(4'h0, m_mode);
        m_hold = 8'h55;
        wr(4'h1, m_hold);
        check_pins("R4 hold D- over diff0");

        // R2 R3 R4 random mix
        for (int i = 0; i < 40; i++) begin
            m_mode = 8'($urandom);
            m_hold = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            wr(4'h0, m_mode);
            wr(4'h1, m_hold);
            check_pins("R4 random mode/hold");
        end

        // R9: monitor registers ignore writes
        wr(4'h2, 8'hFF);
        wr(4'h3, 8'h00);
        check_mon("R9 write ignored");

        // R10: undefined offsets
        for (int i = 4; i < 16; i++) begin
            rd(4'(i), v);
            check("R10 undefined read", v, 8'h00);
        end
        wr(4'h5, 8'h3C);
        wr(4'h9, 8'hC3);
        rd(4'h0, v);
        check("R10 mode unchanged", v, m_mode);
        rd(4'h1, v);
        check("R10 hold unchanged", v, m_hold);

        // R5: latency of SE0 on port 0
        @(negedge clk);
        rx_dp = 4'hE;
        rx_dm = 4'h0;
        repeat (2) @(negedge clk);
        reg_addr = 4'h2;
        #1;
        check("R5 before third edge", reg_rdata, 8'h00);
        @(negedge clk);
        #1;
        check("R5 on third edge", reg_rdata, 8'h01);

        // R6 R7: J then SE0 holds 1, K then SE0 holds 0
        set_lines(4'h0, 4'hF);
        check_mon("R6 all K");
        set_lines(4'h5, 4'hA);
        check_mon("R6 J/K mix");
        set_lines(4'h0, 4'h0);
        check_mon("R7 SE0 holds");
        set_lines(4'hF, 4'hF);
        check_mon("R7 both high holds");

        // R5 R6 R7 random line patterns
        for (int i = 0; i < 60; i++) begin
            set_lines(4'($urandom), 4'($urandom));
            check_mon("R7 random lines");
        end

        // R8: bus reset while port 0 holds J through SE0
        set_lines(4'h1, 4'h0);
        set_lines(4'h0, 4'h0);
        check_mon("R8 pre");
        m_mode = 8'h1B;
        m_hold = 8'h42;
        wr(4'h0, m_mode);
        wr(4'h1, m_hold);
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        reg_addr = 4'h3;
        #1;
        check("R8 diff cleared", reg_rdata, 8'h00);
        reg_addr = 4'h2;
        #1;
        check("R8 se0 cleared", reg_rdata, 8'h00);
        rd(4'h0, v);
        check("R8 mode kept", v, m_mode);
        rd(4'h1, v);
        check("R8 hold kept", v, m_hold);
        check_pins("R8 pins kept");
        m_diff = 4'h0;
        set_lines(4'h0, 4'h0);
        check_mon("R8 diff stays 0 in SE0");
        set_lines(4'h2, 4'h1);
        check_mon("R8 recapture");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule